// File: doc/BRIEF.md
# Call-Windowed Asymmetric Register File

This block is the 16-entry architectural register file of a small CPU. Which physical storage serves a register depends on the current call depth and on whether the access is a read or a write. Registers 0 to 6 are private to each call level. Registers 7 to 9 are one shared copy for all levels. Registers 10 to 13 carry arguments. A level reads the arguments its caller wrote, and when it writes these numbers the values go to the level below it. Registers 14 to 15 carry return values. A level reads the values its most recent callee wrote, and when it writes these numbers the values go to its caller. Values therefore pass between levels with no copy step.

A depth pointer moves down one level on a call strobe and up one level on a return strobe. The number of levels held in hardware is a parameter. When the pointer would leave that range, the block raises sticky flags so that spill or fill logic outside the block can act. The block has two combinational read ports and one write port that updates on the clock edge.

Top module: `rwin_regfile`

## Requirements
- R1: Registers 0–6 are private to each level. A read returns the value that the same level last wrote to that register. Values are kept across deeper calls and are not cleared when a level is entered again.
- R2: Registers 7–9 have one copy. A write at any depth is seen by reads at every depth.
- R3: A write to registers 10–13 at depth d goes to the argument slots of level d+1. It is dropped at the deepest level. At depth d > 0, a read of registers 10–13 returns the argument slots of level d, and a write by level d does not change them.
- R4: At depth 0, a read of registers 10–13 returns zero.
- R5: A write to registers 14–15 at depth d goes to the return slots of level d−1. It is dropped at depth 0. A read of registers 14–15 at depth d returns the return slots of level d, which a write by level d does not change.
- R6: A call strobe alone raises depth_o by one and a return strobe alone lowers it by one. Both strobes in the same cycle leave the depth unchanged. A write in a strobe cycle uses the depth from before the strobe.
- R7: A call strobe at depth LEVELS−1 leaves the depth unchanged and sets the sticky ovf_o flag.
- R8: A return strobe at depth 0 leaves the depth unchanged and sets the sticky unf_o flag.
- R9: flag_clr clears both flags. If an overflow or underflow event happens in the same cycle, that event sets its flag anyway.
- R10: After reset every stored value is zero, depth_o is 0, and both flags are low.
- R11: The read ports decode combinationally with the current depth. A write becomes visible from the cycle after its clock edge, and a same-cycle read of the register being written returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Register number written |
| wr_data | input | DW | Write data |
| rd_addr_a | input | 4 | Register number for read port A |
| rd_data_a | output | DW | Read port A data |
| rd_addr_b | input | 4 | Register number for read port B |
| rd_data_b | output | DW | Read port B data |
| call_i | input | 1 | Call strobe, moves one level deeper |
| ret_i | input | 1 | Return strobe, moves one level back |
| flag_clr | input | 1 | Clears the overflow and underflow flags |
| depth_o | output | $clog2(LEVELS) | Current call depth |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that every input is a known value sampled at the rising edge and held stable between edges. They also assume that a read address held across a cycle is compared only when no call or return strobe occurred in that cycle, because a depth change would legitimately change the data. The bench drives all inputs on the falling edge. About a quarter of cycles carry a call strobe and a quarter a return strobe, so the depth walks through every level and reaches both limits often, while write addresses cover all four register classes. Directed sequences show argument passing and return passing, the zero read at depth 0, and both limit events with and without a clear in the same cycle.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int NLOC     = 7;
  localparam int NGLB     = 3;
  localparam int NARG     = 4;
  localparam int NRET     = 2;
  localparam int GLB_BASE = 7;
  localparam int ARG_BASE = 10;
  localparam int RET_BASE = 14;

  typedef enum logic [1:0] {CLS_LOCAL, CLS_GLOBAL, CLS_ARG, CLS_RET} reg_cls_e;

  function automatic reg_cls_e reg_class(input logic [3:0] a);
    if (int'(a) < GLB_BASE)      return CLS_LOCAL;
    else if (int'(a) < ARG_BASE) return CLS_GLOBAL;
    else if (int'(a) < RET_BASE) return CLS_ARG;
    else                         return CLS_RET;
  endfunction

  function automatic int reg_slot(input logic [3:0] a);
    case (reg_class(a))
      CLS_LOCAL:  return int'(a);
      CLS_GLOBAL: return int'(a) - GLB_BASE;
      CLS_ARG:    return int'(a) - ARG_BASE;
      default:    return int'(a) - RET_BASE;
    endcase
  endfunction
endpackage

// File: rtl/rwin_depth.sv
module rwin_depth #(
  parameter int LEVELS = 4,
  parameter int DPW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           call_i,
  input  logic           ret_i,
  input  logic           flag_clr,
  output logic [DPW-1:0] depth,
  output logic           ovf_q,
  output logic           unf_q,
  output logic           call_ok,
  output logic           ret_ok,
  output logic           ovf_evt,
  output logic           unf_evt
);
  logic at_top, at_bot, call_only, ret_only;

  assign at_top    = (depth == DPW'(LEVELS - 1));
  assign at_bot    = (depth == '0);
  assign call_only = call_i & ~ret_i;
  assign ret_only  = ret_i & ~call_i;
  assign call_ok   = call_only & ~at_top;
  assign ret_ok    = ret_only & ~at_bot;
  assign ovf_evt   = call_only & at_top;
  assign unf_evt   = ret_only & at_bot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (call_ok)     depth <= depth + DPW'(1);
      else if (ret_ok) depth <= depth - DPW'(1);
      ovf_q <= (ovf_q & ~flag_clr) | ovf_evt;
      unf_q <= (unf_q & ~flag_clr) | unf_evt;
    end
  end
endmodule

// File: rtl/rwin_bank.sv
module rwin_bank
  import rwin_pkg::*;
#(
  parameter int DW     = 16,
  parameter int LEVELS = 4,
  parameter int DPW    = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [3:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [DPW-1:0] depth,
  output logic [DW-1:0]  loc_q [LEVELS][NLOC],
  output logic [DW-1:0]  glb_q [NGLB],
  output logic [DW-1:0]  arg_q [LEVELS][NARG],
  output logic [DW-1:0]  ret_q [LEVELS][NRET]
);
  int       d, s;
  reg_cls_e cls;

  always_comb begin
    d   = int'(depth);
    s   = reg_slot(wr_addr);
    cls = reg_class(wr_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LEVELS; l++) begin
        for (int i = 0; i < NLOC; i++) loc_q[l][i] <= '0;
        for (int i = 0; i < NARG; i++) arg_q[l][i] <= '0;
        for (int i = 0; i < NRET; i++) ret_q[l][i] <= '0;
      end
      for (int i = 0; i < NGLB; i++) glb_q[i] <= '0;
    end else if (wr_en) begin
      case (cls)
        CLS_LOCAL:  loc_q[d][s] <= wr_data;
        CLS_GLOBAL: glb_q[s] <= wr_data;
        CLS_ARG:    if (d < LEVELS - 1) arg_q[d+1][s] <= wr_data;
        default:    if (d > 0) ret_q[d-1][s] <= wr_data;
      endcase
    end
  end
endmodule

// File: rtl/rwin_rdport.sv
module rwin_rdport
  import rwin_pkg::*;
#(
  parameter int DW     = 16,
  parameter int LEVELS = 4,
  parameter int DPW    = 2
) (
  input  logic [3:0]     rd_addr,
  input  logic [DPW-1:0] depth,
  input  logic [DW-1:0]  loc_q [LEVELS][NLOC],
  input  logic [DW-1:0]  glb_q [NGLB],
  input  logic [DW-1:0]  arg_q [LEVELS][NARG],
  input  logic [DW-1:0]  ret_q [LEVELS][NRET],
  output logic [DW-1:0]  rd_data
);
  int d, s;

  always_comb begin
    d = int'(depth);
    s = reg_slot(rd_addr);
    case (reg_class(rd_addr))
      CLS_LOCAL:  rd_data = loc_q[d][s];
      CLS_GLOBAL: rd_data = glb_q[s];
      CLS_ARG:    rd_data = (d == 0) ? '0 : arg_q[d][s];
      default:    rd_data = ret_q[d][s];
    endcase
  end
endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter int DW     = 16,
  parameter int LEVELS = 4,
  localparam int DPW   = $clog2(LEVELS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [3:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [3:0]     rd_addr_a,
  output logic [DW-1:0]  rd_data_a,
  input  logic [3:0]     rd_addr_b,
  output logic [DW-1:0]  rd_data_b,
  input  logic           call_i,
  input  logic           ret_i,
  input  logic           flag_clr,
  output logic [DPW-1:0] depth_o,
  output logic           ovf_o,
  output logic           unf_o
);
  localparam int NPORT = 2;

  logic call_ok, ret_ok, ovf_evt, unf_evt;
  logic [DW-1:0] loc_q [LEVELS][NLOC];
  logic [DW-1:0] glb_q [NGLB];
  logic [DW-1:0] arg_q [LEVELS][NARG];
  logic [DW-1:0] ret_q [LEVELS][NRET];
  logic [3:0]    rp_addr [NPORT];
  logic [DW-1:0] rp_data [NPORT];

  rwin_depth #(.LEVELS(LEVELS), .DPW(DPW)) u_depth (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .flag_clr(flag_clr), .depth(depth_o), .ovf_q(ovf_o), .unf_q(unf_o),
    .call_ok(call_ok), .ret_ok(ret_ok), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
  );

  rwin_bank #(.DW(DW), .LEVELS(LEVELS), .DPW(DPW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .depth(depth_o), .loc_q(loc_q), .glb_q(glb_q),
    .arg_q(arg_q), .ret_q(ret_q)
  );

  assign rp_addr[0] = rd_addr_a;
  assign rp_addr[1] = rd_addr_b;
  assign rd_data_a  = rp_data[0];
  assign rd_data_b  = rp_data[1];

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    rwin_rdport #(.DW(DW), .LEVELS(LEVELS), .DPW(DPW)) u_rd (
      .rd_addr(rp_addr[p]), .depth(depth_o), .loc_q(loc_q), .glb_q(glb_q),
      .arg_q(arg_q), .ret_q(ret_q), .rd_data(rp_data[p])
    );
  end
endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
  parameter int DW     = 16,
  parameter int LEVELS = 4,
  parameter int DPW    = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [3:0]     wr_addr,
  input logic [DW-1:0]  wr_data,
  input logic [3:0]     rd_addr_a,
  input logic [DW-1:0]  rd_data_a,
  input logic           call_i,
  input logic           ret_i,
  input logic           flag_clr,
  input logic [DPW-1:0] depth_o,
  input logic           ovf_o,
  input logic           unf_o,
  input logic           call_ok,
  input logic           ovf_evt,
  input logic           unf_evt
);
  // R1
  local_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < 4'd7 && !call_i && !ret_i)
    |=> (rd_addr_a != $past(wr_addr) || rd_data_a == $past(wr_data)));

  // R2
  global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= 4'd7 && wr_addr <= 4'd9)
    |=> (rd_addr_a != $past(wr_addr) || rd_data_a == $past(wr_data)));

  // R3 R5
  asym_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= 4'd10 && !call_i && !ret_i && rd_addr_a == wr_addr)
    |=> (rd_addr_a != $past(rd_addr_a) || rd_data_a == $past(rd_data_a)));

  // R4
  arg_root_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_o == '0 && rd_addr_a >= 4'd10 && rd_addr_a <= 4'd13)
    |-> (rd_data_a == '0));

  // R6
  depth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_ok |=> (depth_o == DPW'($past(depth_o) + DPW'(1))));

  // R6
  depth_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=> $stable(depth_o));

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (ovf_o && $stable(depth_o)));

  // R8
  unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> (unf_o && $stable(depth_o)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !flag_clr) |=> ovf_o);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ovf_evt && !unf_evt) |=> (!ovf_o && !unf_o));

  // R10
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (depth_o == '0 && !ovf_o && !unf_o));
endmodule

bind rwin_regfile rwin_regfile_chk #(.DW(DW), .LEVELS(LEVELS), .DPW(DPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
  .call_i(call_i), .ret_i(ret_i), .flag_clr(flag_clr), .depth_o(depth_o),
  .ovf_o(ovf_o), .unf_o(unf_o), .call_ok(call_ok), .ovf_evt(ovf_evt),
  .unf_evt(unf_evt)
);

// File: tb/rwin_regfile_bench.sv
`timescale 1ns/1ps
module rwin_regfile_bench;
  localparam int DW  = 16;
  localparam int L   = 4;
  localparam int DPW = $clog2(L);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0, flag_clr = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr_a = '0, rd_addr_b = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data_a, rd_data_b;
  logic [DPW-1:0] depth_o;
  logic ovf_o, unf_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] m_loc [L][7];
  logic [DW-1:0] m_glb [3];
  logic [DW-1:0] m_arg [L][4];
  logic [DW-1:0] m_ret [L][2];
  int m_depth = 0;
  bit m_ovf = 0, m_unf = 0;

  always #4 clk = ~clk;

  rwin_regfile #(.DW(DW), .LEVELS(L)) u_rwin_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .call_i(call_i),
    .ret_i(ret_i), .flag_clr(flag_clr), .depth_o(depth_o), .ovf_o(ovf_o),
    .unf_o(unf_o)
  );

  function automatic logic [DW-1:0] mread(input logic [3:0] a);
    int n = int'(a);
    if (n <= 6)       return m_loc[m_depth][n];
    else if (n <= 9)  return m_glb[n-7];
    else if (n <= 13) return (m_depth == 0) ? '0 : m_arg[m_depth][n-10];
    else              return m_ret[m_depth][n-14];
  endfunction

  function automatic string rtag(input logic [3:0] a);
    int n = int'(a);
    if (wr_en && wr_addr == a) return "R11";
    if (n <= 6)       return "R1";
    else if (n <= 9)  return "R2";
    else if (n <= 13) return (m_depth == 0) ? "R4" : "R3";
    else              return "R5";
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    int n = int'(wr_addr);
    int d = m_depth;
    bit ovf_e, unf_e;
    if (wr_en) begin
      if (n <= 6)       m_loc[d][n] = wr_data;
      else if (n <= 9)  m_glb[n-7] = wr_data;
      else if (n <= 13) begin if (d != L-1) m_arg[d+1][n-10] = wr_data; end
      else              begin if (d != 0)   m_ret[d-1][n-14] = wr_data; end
    end
    ovf_e = call_i && !ret_i && d == L-1;
    unf_e = ret_i && !call_i && d == 0;
    if (call_i && !ret_i && !ovf_e) m_depth = d + 1;
    if (ret_i && !call_i && !unf_e) m_depth = d - 1;
    if (flag_clr) begin m_ovf = 0; m_unf = 0; end
    if (ovf_e) m_ovf = 1;
    if (unf_e) m_unf = 1;
  endtask

  task automatic step(input bit we, input logic [3:0] wa, input logic [DW-1:0] wd,
                      input logic [3:0] ra, input logic [3:0] rb,
                      input bit c, input bit r, input bit clr, input string ovr);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
    call_i = c; ret_i = r; flag_clr = clr;
    #1;
    chk(ovr == "" ? rtag(ra) : ovr, rd_data_a, mread(ra));
    chk(ovr == "" ? rtag(rb) : ovr, rd_data_b, mread(rb));
    chk(ovr == "" ? "R6" : ovr, DW'(depth_o), DW'(m_depth));
    chk(ovr == "" ? "R7" : ovr, DW'(ovf_o), DW'(m_ovf));
    chk(ovr == "" ? "R8" : ovr, DW'(unf_o), DW'(m_unf));
    @(posedge clk);
    model_update();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int l = 0; l < L; l++) begin
      for (int i = 0; i < 7; i++) m_loc[l][i] = '0;
      for (int i = 0; i < 4; i++) m_arg[l][i] = '0;
      for (int i = 0; i < 2; i++) m_ret[l][i] = '0;
    end
    for (int i = 0; i < 3; i++) m_glb[i] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: every register reads zero after reset
    for (int i = 0; i < 8; i++)
      step(0, 4'd0, '0, 4'(2*i), 4'(2*i+1), 0, 0, 0, "R10");
    // R3: argument passing into callee, callee cannot alter its own args
    step(1, 4'd10, 16'h1111, 4'd10, 4'd11, 0, 0, 0, "");
    step(0, 4'd0, '0, 4'd10, 4'd14, 1, 0, 0, "");
    step(1, 4'd10, 16'h2222, 4'd10, 4'd10, 0, 0, 0, "");
    step(0, 4'd0, '0, 4'd10, 4'd10, 0, 0, 0, "R3");
    // R5: return value passing to caller
    step(1, 4'd14, 16'h3333, 4'd14, 4'd15, 0, 0, 0, "");
    step(0, 4'd0, '0, 4'd14, 4'd14, 0, 1, 0, "R5");
    step(0, 4'd0, '0, 4'd14, 4'd10, 0, 0, 0, "");
    // R6: write during call uses old depth; both strobes hold depth
    step(1, 4'd3, 16'h4444, 4'd3, 4'd3, 1, 0, 0, "");
    step(0, 4'd0, '0, 4'd3, 4'd3, 1, 1, 0, "R6");
    // R7: overflow at deepest level, then R9 clear
    for (int i = 0; i < 4; i++) step(0, 4'd0, '0, 4'd3, 4'd10, 1, 0, 0, "");
    step(0, 4'd0, '0, 4'd3, 4'd10, 0, 0, 0, "R7");
    step(0, 4'd0, '0, 4'd3, 4'd10, 1, 0, 1, "R9");
    step(0, 4'd0, '0, 4'd3, 4'd10, 0, 0, 1, "R9");
    // R8: underflow at depth 0
    for (int i = 0; i < 5; i++) step(0, 4'd0, '0, 4'd14, 4'd10, 0, 1, 0, "");
    step(0, 4'd0, '0, 4'd14, 4'd10, 0, 0, 0, "R8");
    step(0, 4'd0, '0, 4'd14, 4'd10, 0, 0, 1, "R9");
    // random mix
    for (int k = 0; k < 3000; k++) begin
      int rc = $urandom_range(99);
      step($urandom_range(99) < 60, 4'($urandom_range(15)), DW'($urandom()),
           4'($urandom_range(15)), 4'($urandom_range(15)),
           rc < 25 || rc >= 95, rc >= 25 && rc < 50 || rc >= 95,
           $urandom_range(99) < 3, "");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule